// File: doc/BRIEF.md
# Receive Descriptor Ring Filler

This block takes frames from a receive path and spreads them over a circular ring of buffer descriptors held in memory. Each descriptor is two 32-bit words. The first word carries a 16-bit flag field and a 16-bit length. The second word carries the address of the data buffer. Starting at its ring pointer, the block reads a descriptor. If the descriptor is marked empty, the block writes a run of bytes into its buffer, then writes the flag and length word back. It then steps to the next descriptor, or jumps back to the ring base when the wrap flag is set.

The frame source offers a length on a start handshake. It then supplies the frame bytes one at a time, advancing whenever `dat_take` is high. The block adds the trailing bytes itself: four CRC bytes (zero, since no CRC is computed), plus zero pad that brings a short payload up to the minimum size. When a parse depth is configured, the block also places a zeroed control block ahead of the data.

When the ring runs out of empty descriptors before the frame is fully placed, the block halts the ring and keeps the count of unplaced bytes. Software refills descriptors and pulses a restart. The frame then resumes exactly where it stopped.

Top module: `rx_ring_filler`

## Requirements
- R1: `frm_ready` is high only in the idle state, with `cfg_rx_en`=1, `cfg_grace_stop`=0, `ring_halted`=0 and no frame pending. While it is low, `frm_valid` is not taken.
- R2: An accepted frame with length below 60 and `cfg_short_ok`=0 is discarded. No memory write is made, no byte is taken, the pointer does not change and nothing stays pending.
- R3: Each stored frame is followed by zero bytes: 4 CRC bytes, plus (60 − length) pad bytes when the length is below 60. The frame size is therefore max(length,60)+4.
- R4: When `cfg_parse_depth` is non-zero, 8+`cfg_align` zero bytes are placed before the data. They occupy the front of the first descriptor's buffer and count in its length.
- R5: A descriptor receives at most `cfg_max_buf` bytes. Bytes go in the order control block, data, pad, each one written to buffer address plus its offset. The written length field equals the old length plus the bytes placed, and the empty flag is cleared.
- R6: The first descriptor of a frame gets the first flag. The descriptor holding the final byte gets the last flag. A descriptor used after a resume does not get the first flag.
- R7: The last descriptor gets the length-violation flag when max(length,60)+4 ≥ `cfg_max_frame`, and not otherwise.
- R8: During a descriptor write-back whose interrupt flag is set, the block pulses `ev_frame` for one cycle if that descriptor is the last one, and `ev_buf` for one cycle if it is not.
- R9: After each used descriptor the pointer moves to the ring base if the wrap flag is set, and otherwise advances by 8. A non-empty descriptor is not passed, so `ring_ptr` always names the next unused descriptor. `ptr_wr` loads a pointer with bits 2:0 cleared, while idle.
- R10: If a walk ends with bytes still unplaced (a non-empty descriptor, or a return to the starting descriptor), `ring_halted` is set and the frame stays pending. `ring_restart` clears the halt and placement resumes with the next byte.
- R11: A descriptor at address P has word0 = {flags, length} at P and its buffer address at P+4. Read data returns one cycle after `mem_rd`. Only one memory operation is active per cycle. Flag bits: empty 15, wrap 13, interrupt 12, last 11, first 10, length-violation 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_grace_stop | input | 1 | Stop accepting new frames |
| cfg_short_ok | input | 1 | Keep frames shorter than 60 bytes |
| cfg_parse_depth | input | PDW | Non-zero enables the leading control block |
| cfg_align | input | ALW | Extra control block bytes beyond 8 |
| cfg_ring_base | input | AW | Ring base address |
| cfg_max_buf | input | 16 | Byte limit per descriptor |
| cfg_max_frame | input | 16 | Length-violation threshold |
| ptr_wr | input | 1 | Load the ring pointer |
| ptr_wdata | input | AW | Pointer value to load |
| ring_restart | input | 1 | Clear the halt and resume |
| ring_ptr | output | AW | Current descriptor pointer |
| ring_halted | output | 1 | Ring halted with data left |
| frm_pending | output | 1 | A frame is not yet fully placed |
| frm_valid | input | 1 | Frame start offered |
| frm_len | input | 16 | Frame length in bytes |
| frm_ready | output | 1 | Frame start accepted when high with valid |
| dat_byte | input | 8 | Current frame byte |
| dat_take | output | 1 | Current byte consumed |
| mem_rd | output | 1 | Word read |
| mem_wr | output | 1 | Word write |
| mem_bwr | output | 1 | Byte write, data in bits 7:0 |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_rd |
| ev_frame | output | 1 | Frame-received event pulse |
| ev_buf | output | 1 | Buffer-received event pulse |

## Verification
Some properties are checked by assertions on every cycle. These cover memory access: there is never more than one operation at a time, no memory traffic happens without a pending frame, and no byte write reaches past the per-descriptor limit. They also cover the counters (the frame counter never steps once its work is done, and a loaded frame size never falls under 64), the persistence of the halt until a restart, and a pointer that is always 8-byte aligned. Other behaviour only shows through the directed scenarios. These cover the exact byte layout of control block, data and pad in each buffer, and the flag and length words written back. They also cover the wrap and non-empty stopping rules, a resume that carries on mid-frame without repeating the first flag, the event pulses, and the short-frame drop.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned LEN_W      = 16;
  localparam int unsigned DESC_BYTES = 8;

  localparam int unsigned FLG_EMPTY = 15;
  localparam int unsigned FLG_WRAP  = 13;
  localparam int unsigned FLG_INT   = 12;
  localparam int unsigned FLG_LAST  = 11;
  localparam int unsigned FLG_FIRST = 10;
  localparam int unsigned FLG_LENV  = 5;

  typedef enum logic [1:0] {SRC_CB, SRC_DATA, SRC_PAD} src_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_HDR, ST_RD_PTR, ST_CHECK, ST_FILL, ST_WBACK
  } st_e;
endpackage

// File: rtl/rxr_frame_acct.sv
module rxr_frame_acct
  import rxr_pkg::*;
#(
  parameter int unsigned MIN_LEN = 60,
  parameter int unsigned CRC_LEN = 4,
  parameter int unsigned CB_BASE = 8,
  parameter int unsigned ALW     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             cb_en,
  input  logic [ALW-1:0]   cb_align,
  input  logic             step,
  output src_e             src,
  output logic             left_one,
  output logic             all_done,
  output logic [LEN_W:0]   total
);
  localparam int unsigned CBW  = $clog2(CB_BASE + (1 << ALW)) + 1;
  localparam int unsigned PADW = $clog2(MIN_LEN + CRC_LEN + 1);
  localparam int unsigned SUMW = LEN_W + 2;

  logic [CBW-1:0]   cb_q,  cb_d;
  logic [LEN_W-1:0] dat_q, dat_d;
  logic [PADW-1:0]  pad_q, pad_d;
  logic [LEN_W:0]   tot_q, tot_d;
  logic             short_len;

  assign short_len = len < LEN_W'(MIN_LEN);
  assign src = (cb_q != '0) ? SRC_CB : ((dat_q != '0) ? SRC_DATA : SRC_PAD);
  assign all_done = (cb_q == '0) && (dat_q == '0) && (pad_q == '0);
  assign left_one = (SUMW'(cb_q) + SUMW'(dat_q) + SUMW'(pad_q)) == SUMW'(1);
  assign total = tot_q;

  always_comb begin
    cb_d  = cb_q;
    dat_d = dat_q;
    pad_d = pad_q;
    tot_d = tot_q;
    if (load) begin
      cb_d  = cb_en ? (CBW'(CB_BASE) + CBW'(cb_align)) : '0;
      dat_d = len;
      pad_d = short_len ? (PADW'(CRC_LEN) + PADW'(LEN_W'(MIN_LEN) - len))
                        : PADW'(CRC_LEN);
      tot_d = (short_len ? (LEN_W+1)'(MIN_LEN) : {1'b0, len}) + (LEN_W+1)'(CRC_LEN);
    end else if (step) begin
      unique case (src)
        SRC_CB:   cb_d  = cb_q - CBW'(1);
        SRC_DATA: dat_d = dat_q - LEN_W'(1);
        default:  if (pad_q != '0) pad_d = pad_q - PADW'(1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cb_q  <= '0;
      dat_q <= '0;
      pad_q <= '0;
      tot_q <= '0;
    end else if (load || step) begin
      cb_q  <= cb_d;
      dat_q <= dat_d;
      pad_q <= pad_d;
      tot_q <= tot_d;
    end
  end

  AST_STEP_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !all_done); // R5
  AST_SIZE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (tot_q >= (LEN_W+1)'(MIN_LEN + CRC_LEN))); // R3
endmodule

// File: rtl/rxr_desc_word.sv
module rxr_desc_word
  import rxr_pkg::*;
(
  input  logic [31:0]      old_w,
  input  logic [LEN_W-1:0] add_len,
  input  logic             first,
  input  logic             last,
  input  logic             lenv,
  input  logic             wb_en,
  output logic [31:0]      new_w,
  output logic             ev_frame,
  output logic             ev_buf
);
  logic [15:0] flags;

  always_comb begin
    flags = old_w[31:16];
    flags[FLG_EMPTY] = 1'b0;
    if (first) flags[FLG_FIRST] = 1'b1;
    if (last)  flags[FLG_LAST]  = 1'b1;
    if (last && lenv) flags[FLG_LENV] = 1'b1;
    new_w = {flags, old_w[15:0] + add_len};
  end

  assign ev_frame = wb_en && old_w[16+FLG_INT] && last;
  assign ev_buf   = wb_en && old_w[16+FLG_INT] && !last;
endmodule

// File: rtl/rx_ring_filler.sv
module rx_ring_filler
  import rxr_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned PDW     = 2,
  parameter int unsigned ALW     = 5,
  parameter int unsigned MIN_LEN = 60,
  parameter int unsigned CRC_LEN = 4,
  parameter int unsigned CB_BASE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_rx_en,
  input  logic             cfg_grace_stop,
  input  logic             cfg_short_ok,
  input  logic [PDW-1:0]   cfg_parse_depth,
  input  logic [ALW-1:0]   cfg_align,
  input  logic [AW-1:0]    cfg_ring_base,
  input  logic [LEN_W-1:0] cfg_max_buf,
  input  logic [LEN_W-1:0] cfg_max_frame,
  input  logic             ptr_wr,
  input  logic [AW-1:0]    ptr_wdata,
  input  logic             ring_restart,
  output logic [AW-1:0]    ring_ptr,
  output logic             ring_halted,
  output logic             frm_pending,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  output logic             frm_ready,
  input  logic [7:0]       dat_byte,
  output logic             dat_take,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             mem_bwr,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             ev_frame,
  output logic             ev_buf
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(DESC_BYTES - 1);

  st_e              st_q, st_d;
  logic [AW-1:0]    ptr_q, ptr_d, start_q, start_d, buf_q, buf_d, ptr_next;
  logic             halt_q, halt_d, pend_q, pend_d, first_q, first_d;
  logic [31:0]      w0_q, w0_d, new_w;
  logic [LEN_W-1:0] cnt_q, cnt_d;

  logic             accept, keep, step, wb_en;
  src_e             src;
  logic             left_one, all_done;
  logic [LEN_W:0]   total;

  rxr_frame_acct #(
    .MIN_LEN(MIN_LEN), .CRC_LEN(CRC_LEN), .CB_BASE(CB_BASE), .ALW(ALW)
  ) acct_i (
    .clk(clk), .rst_n(rst_n), .load(keep), .len(frm_len),
    .cb_en(cfg_parse_depth != '0), .cb_align(cfg_align), .step(step),
    .src(src), .left_one(left_one), .all_done(all_done), .total(total)
  );

  rxr_desc_word word_i (
    .old_w(w0_q), .add_len(cnt_q), .first(first_q), .last(all_done),
    .lenv(total >= {1'b0, cfg_max_frame}), .wb_en(wb_en),
    .new_w(new_w), .ev_frame(ev_frame), .ev_buf(ev_buf)
  );

  assign frm_ready = (st_q == ST_IDLE) && !pend_q && !halt_q &&
                     cfg_rx_en && !cfg_grace_stop;
  assign accept = frm_valid && frm_ready;
  assign keep   = accept && (cfg_short_ok || (frm_len >= LEN_W'(MIN_LEN)));
  assign step   = (st_q == ST_FILL);
  assign wb_en  = (st_q == ST_WBACK);
  assign ptr_next = w0_q[16+FLG_WRAP] ? (cfg_ring_base & ALIGN_MASK)
                                      : (ptr_q + AW'(DESC_BYTES));

  // memory port
  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_bwr   = 1'b0;
    mem_addr  = ptr_q;
    mem_wdata = '0;
    dat_take  = 1'b0;
    unique case (st_q)
      ST_RD_HDR: mem_rd = 1'b1;
      ST_RD_PTR: begin
        mem_rd   = 1'b1;
        mem_addr = ptr_q + AW'(4);
      end
      ST_FILL: begin
        mem_bwr   = 1'b1;
        mem_addr  = buf_q + AW'(cnt_q);
        dat_take  = (src == SRC_DATA);
        mem_wdata = {24'h0, (src == SRC_DATA) ? dat_byte : 8'h00};
      end
      ST_WBACK: begin
        mem_wr    = 1'b1;
        mem_wdata = new_w;
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    start_d = start_q;
    buf_d   = buf_q;
    halt_d  = halt_q;
    pend_d  = pend_q;
    first_d = first_q;
    w0_d    = w0_q;
    cnt_d   = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (ring_restart) halt_d = 1'b0;
        if (ptr_wr) ptr_d = ptr_wdata & ALIGN_MASK;
        if (keep) begin
          pend_d  = 1'b1;
          first_d = 1'b1;
          start_d = ptr_q;
          st_d    = ST_RD_HDR;
        end else if (pend_q && !halt_q) begin
          start_d = ptr_q;
          st_d    = ST_RD_HDR;
        end
      end
      ST_RD_HDR: st_d = ST_RD_PTR;
      ST_RD_PTR: begin
        w0_d = mem_rdata;
        st_d = ST_CHECK;
      end
      ST_CHECK: begin
        buf_d = mem_rdata[AW-1:0];
        cnt_d = '0;
        if (!w0_q[16+FLG_EMPTY]) begin
          halt_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (cfg_max_buf == '0) begin
          st_d = ST_WBACK;
        end else begin
          st_d = ST_FILL;
        end
      end
      ST_FILL: begin
        cnt_d = cnt_q + LEN_W'(1);
        if (left_one || (cnt_d == cfg_max_buf)) st_d = ST_WBACK;
      end
      ST_WBACK: begin
        first_d = 1'b0;
        ptr_d   = ptr_next;
        if (all_done) begin
          pend_d = 1'b0;
          st_d   = ST_IDLE;
        end else if (ptr_next == start_q) begin
          halt_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          st_d = ST_RD_HDR;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      start_q <= '0;
      buf_q   <= '0;
      halt_q  <= 1'b0;
      pend_q  <= 1'b0;
      first_q <= 1'b0;
      w0_q    <= '0;
      cnt_q   <= '0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      start_q <= start_d;
      buf_q   <= buf_d;
      halt_q  <= halt_d;
      pend_q  <= pend_d;
      first_q <= first_d;
      w0_q    <= w0_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ring_ptr    = ptr_q;
  assign ring_halted = halt_q;
  assign frm_pending = pend_q;

  AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd, mem_wr, mem_bwr}) <= 1); // R11
  AST_MEM_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || mem_bwr) |-> frm_pending); // R2
  AST_BYTE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_bwr |-> (cnt_q < cfg_max_buf)); // R5
  AST_TAKE_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dat_take |-> (mem_bwr && mem_wdata[7:0] == dat_byte)); // R5
  AST_EVENT_ON_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame || ev_buf) |-> mem_wr); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_halted && !ring_restart) |=> ring_halted); // R10
  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ring_ptr[2:0] == 3'b000); // R9
endmodule

// File: tb/rx_ring_filler_tb_top.sv
module rx_ring_filler_tb_top;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_rx_en = 1'b1, cfg_grace_stop = 1'b0, cfg_short_ok = 1'b0;
  logic [1:0]  cfg_parse_depth = 2'd0;
  logic [4:0]  cfg_align = 5'd0;
  logic [31:0] cfg_ring_base = BASE;
  logic [15:0] cfg_max_buf = 16'd64, cfg_max_frame = 16'd1518;
  logic        ptr_wr = 1'b0, ring_restart = 1'b0, frm_valid = 1'b0;
  logic [31:0] ptr_wdata = '0;
  logic [15:0] frm_len = '0;
  logic [31:0] ring_ptr, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        ring_halted, frm_pending, frm_ready, dat_take;
  logic        mem_rd, mem_wr, mem_bwr, ev_frame, ev_buf;
  logic [7:0]  dat_byte;

  logic [7:0]  mem [0:1023];
  logic        tb_we = 1'b0;
  logic [31:0] tb_addr = '0, tb_word = '0;
  int          take_cnt = 0, take_base = 0, wr_cnt = 0, evf_cnt = 0, evb_cnt = 0;
  logic [7:0]  seed = '0;
  int          checks = 0, fails = 0;
  bit          finished = 1'b0;

  rx_ring_filler dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .cfg_grace_stop(cfg_grace_stop),
    .cfg_short_ok(cfg_short_ok), .cfg_parse_depth(cfg_parse_depth), .cfg_align(cfg_align),
    .cfg_ring_base(cfg_ring_base), .cfg_max_buf(cfg_max_buf), .cfg_max_frame(cfg_max_frame),
    .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .ring_restart(ring_restart),
    .ring_ptr(ring_ptr), .ring_halted(ring_halted), .frm_pending(frm_pending),
    .frm_valid(frm_valid), .frm_len(frm_len), .frm_ready(frm_ready),
    .dat_byte(dat_byte), .dat_take(dat_take), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_bwr(mem_bwr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ev_frame(ev_frame), .ev_buf(ev_buf)
  );

  assign dat_byte = 8'(int'(seed) + take_cnt - take_base);

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return {mem[a[9:0]+3], mem[a[9:0]+2], mem[a[9:0]+1], mem[a[9:0]]};
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= rd_word(mem_addr);
    if (mem_wr) begin
      for (int b = 0; b < 4; b++) mem[mem_addr[9:0] + 10'(b)] <= mem_wdata[8*b +: 8];
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_bwr) begin
      mem[mem_addr[9:0]] <= mem_wdata[7:0];
      wr_cnt <= wr_cnt + 1;
    end
    if (tb_we)
      for (int b = 0; b < 4; b++) mem[tb_addr[9:0] + 10'(b)] <= tb_word[8*b +: 8];
    if (dat_take) take_cnt <= take_cnt + 1;
    if (ev_frame) evf_cnt <= evf_cnt + 1;
    if (ev_buf)   evb_cnt <= evb_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [31:0] a, input logic [31:0] v);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = a; tb_word = v;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  // n descriptors at BASE, buffers from bufb every 0x40, prefilled with AA
  task automatic setup_ring(input int n, input logic [31:0] bufb);
    for (int i = 0; i < n; i++) begin
      wr_word(BASE + 32'(8*i), {((i == n-1) ? 16'hB000 : 16'h9000), 16'h0});
      wr_word(BASE + 32'(8*i) + 4, bufb + 32'(64*i));
      for (int w = 0; w < 16; w++) wr_word(bufb + 32'(64*i) + 32'(4*w), 32'hAAAAAAAA);
    end
  endtask

  task automatic load_ptr(input logic [31:0] v);
    @(negedge clk); ptr_wr = 1'b1; ptr_wdata = v;
    @(negedge clk); ptr_wr = 1'b0;
  endtask

  task automatic send(input logic [15:0] len, input logic [7:0] s);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = len; seed = s; take_base = take_cnt;
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic settle();
    while (frm_pending && !ring_halted) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk); ring_restart = 1'b1;
    @(negedge clk); ring_restart = 1'b0;
  endtask

  // compare buffer bytes against stream offsets k0..k0+cnt-1
  task automatic chk_stream(input string req, input logic [31:0] bufa, input int k0,
                            input int cnt, input int cb, input int len, input logic [7:0] s);
    int bad = 0;
    logic [7:0] e, a;
    logic [7:0] fa = '0, fe = '0;
    for (int k = k0; k < k0 + cnt; k++) begin
      if (k < cb) e = 8'h00;
      else if (k < cb + len) e = 8'(int'(s) + k - cb);
      else e = 8'h00;
      a = mem[bufa[9:0] + 10'(k - k0)];
      if (a !== e) begin
        if (bad == 0) begin fa = a; fe = e; end
        bad++;
      end
    end
    chk(req, {24'h0, fa}, {24'h0, fe});
  endtask

  task automatic t_reset();
    chk("R1 reset ready", {31'h0, frm_ready}, 32'd1);
    chk("R10 reset halted", {31'h0, ring_halted}, 32'd0);
    chk("R2 reset pending", {31'h0, frm_pending}, 32'd0);
    chk("R9 reset ptr", ring_ptr, 32'h0);
  endtask

  task automatic t_admission();
    @(negedge clk); cfg_rx_en = 1'b0;
    @(negedge clk); chk("R1 ready with rx disabled", {31'h0, frm_ready}, 32'd0);
    cfg_rx_en = 1'b1; cfg_grace_stop = 1'b1;
    @(negedge clk); chk("R1 ready with stop", {31'h0, frm_ready}, 32'd0);
    cfg_grace_stop = 1'b0;
    load_ptr(32'h10D);
    chk("R9 ptr load clears low bits", ring_ptr, 32'h108);
  endtask

  task automatic t_basic();
    int f0 = evf_cnt, b0 = evb_cnt;
    setup_ring(4, 32'h200); load_ptr(BASE);
    cfg_max_buf = 16'd64; cfg_max_frame = 16'd1518;
    send(16'd100, 8'h11); settle();
    chk("R5 R6 desc0 word", rd_word(BASE), 32'h1400_0040);
    chk("R6 R7 desc1 word", rd_word(BASE + 8), 32'h1800_0028);
    chk("R5 desc2 untouched", rd_word(BASE + 16), 32'h9000_0000);
    chk_stream("R5 desc0 bytes", 32'h200, 0, 64, 0, 100, 8'h11);
    chk_stream("R3 desc1 data and crc", 32'h240, 64, 40, 0, 100, 8'h11);
    chk("R9 ptr after frame", ring_ptr, BASE + 16);
    chk("R8 frame event", 32'(evf_cnt - f0), 32'd1);
    chk("R8 buffer event", 32'(evb_cnt - b0), 32'd1);
    chk("R2 pending cleared", {31'h0, frm_pending}, 32'd0);
  endtask

  task automatic t_drop();
    int w0 = wr_cnt, t0 = take_cnt;
    load_ptr(BASE); cfg_short_ok = 1'b0;
    send(16'd40, 8'h22); repeat (6) @(negedge clk);
    chk("R2 no writes", 32'(wr_cnt - w0), 32'd0);
    chk("R2 no bytes taken", 32'(take_cnt - t0), 32'd0);
    chk("R2 ptr kept", ring_ptr, BASE);
    chk("R2 not pending", {31'h0, frm_pending}, 32'd0);
  endtask

  task automatic t_short();
    setup_ring(2, 32'h200); load_ptr(BASE);
    cfg_short_ok = 1'b1; cfg_max_frame = 16'd64;
    send(16'd40, 8'h30); settle();
    chk("R3 R7 desc0 word", rd_word(BASE), 32'h1C20_0040);
    chk_stream("R3 short frame pad", 32'h200, 0, 64, 0, 40, 8'h30);
    chk("R9 ptr short", ring_ptr, BASE + 8);
    cfg_short_ok = 1'b0; cfg_max_frame = 16'd1518;
  endtask

  task automatic t_ctrl_block();
    setup_ring(3, 32'h200); load_ptr(BASE);
    cfg_parse_depth = 2'd1; cfg_align = 5'd2;
    send(16'd60, 8'h50); settle();
    chk("R4 desc0 word", rd_word(BASE), 32'h1400_0040);
    chk("R4 desc1 word", rd_word(BASE + 8), 32'h1800_000A);
    chk_stream("R4 block then data", 32'h200, 0, 64, 10, 60, 8'h50);
    chk_stream("R3 tail", 32'h240, 64, 10, 10, 60, 8'h50);
    cfg_parse_depth = 2'd0; cfg_align = 5'd0;
  endtask

  task automatic t_wrap_halt();
    int f0, b0;
    setup_ring(2, 32'h200); load_ptr(BASE);
    cfg_max_buf = 16'd32;
    f0 = evf_cnt; b0 = evb_cnt;
    send(16'd100, 8'h70); settle();
    chk("R10 halted on return", {31'h0, ring_halted}, 32'd1);
    chk("R10 still pending", {31'h0, frm_pending}, 32'd0 + 32'd1);
    chk("R1 ready while halted", {31'h0, frm_ready}, 32'd0);
    chk("R9 ptr wrapped", ring_ptr, BASE);
    chk("R6 desc0 word", rd_word(BASE), 32'h1400_0020);
    chk("R9 desc1 word", rd_word(BASE + 8), 32'h3000_0020);
    chk("R8 no frame event yet", 32'(evf_cnt - f0), 32'd0);
    chk_stream("R5 first part", 32'h240, 32, 32, 0, 100, 8'h70);
    setup_ring(2, 32'h300); restart(); settle();
    chk("R10 halt cleared", {31'h0, ring_halted}, 32'd0);
    chk("R6 resumed desc0 no first", rd_word(BASE), 32'h1000_0020);
    chk("R6 resumed desc1 last", rd_word(BASE + 8), 32'h3800_0008);
    chk_stream("R10 resumed bytes", 32'h300, 64, 32, 0, 100, 8'h70);
    chk_stream("R10 resumed tail", 32'h340, 96, 8, 0, 100, 8'h70);
    chk("R9 ptr after resume", ring_ptr, BASE);
    chk("R8 events total", 32'(evb_cnt - b0) * 32'd16 + 32'(evf_cnt - f0), 32'd49);
    cfg_max_buf = 16'd64;
  endtask

  task automatic t_nonempty();
    setup_ring(3, 32'h200); wr_word(BASE + 8, 32'h1000_0000); load_ptr(BASE);
    send(16'd80, 8'h90); settle();
    chk("R10 halt on busy desc", {31'h0, ring_halted}, 32'd1);
    chk("R9 ptr stops at busy desc", ring_ptr, BASE + 8);
    chk("R5 busy desc untouched", rd_word(BASE + 8), 32'h1000_0000);
    wr_word(BASE + 8, 32'h9000_0000); restart(); settle();
    chk("R6 tail desc word", rd_word(BASE + 8), 32'h1800_0014);
    chk_stream("R10 tail bytes", 32'h240, 64, 20, 0, 80, 8'h90);
    chk("R9 ptr end", ring_ptr, BASE + 16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_admission();
    t_basic();
    t_drop();
    t_short();
    t_ctrl_block();
    t_wrap_halt();
    t_nonempty();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule